// File: doc/BRIEF.md
# Serial Link Input Frame Assembler

This block sits on the codec side of a time-division serial audio link and produces the frames that travel from codec to controller. Each frame is 256 bits long. It opens with a 16-bit tag slot, and twelve 20-bit data slots follow. The bits leave on one serial output, most significant bit first. A one-cycle sync pulse marks the start of each frame. On that edge the block captures the whole content of the new frame: the current left and right ADC samples, any pending register-read response, and the general-purpose status word. It then shifts the frame out one bit per clock.

A configuration register at index 6Eh steers the ADC pair to one of four slot pairs. A register-read response always travels as one unit: the address goes in slot 1 and the data in slot 2 of the same frame. It appears in the frame that starts after the request arrived. The tag slot flags exactly the slots that carry data.

Top module: `slink_frame_asm`

## Requirements
- R1: While reset is asserted, and after reset until the first sync pulse, `sdata` is 0. Reset also sets the slot-pair selection to code 0 (slots 3 and 4).
- R2: On the clock edge where `frame_sync` is high, a new frame is loaded and its bit 255 appears on `sdata`. Each following edge moves to the next lower bit. Bits 255..240 are the tag, and slot s occupies bits 239-20(s-1) down to 220-20(s-1). Slots that carry no data (for example slot 5) are all zero.
- R3: When `adc_valid` is high at the sync edge, the left and right samples are placed in the pair given by selection code 0 (slots 3 and 4), 1 (slots 7 and 8), 2 (slots 6 and 9) or 3 (slots 10 and 11). When `adc_valid` is low, those slots are zero and untagged.
- R4: A write with `cfg_wr` high sets the selection code from `cfg_wdata[2:0]` only when `cfg_idx` equals 6Eh. Writes to other indices leave the selection unchanged. A new selection applies from the next sync edge after the write.
- R5: Selection codes 4 to 7 place the ADC pair in slots 3 and 4.
- R6: A `rsp_req` pulse records `rsp_addr` and `rsp_data`. The frame loaded at the next sync edge strictly after the pulse carries the address in slot 1 bits 18..12 (all other slot-1 bits 0) and the data in slot 2 bits 19..4 (bits 3..0 zero). The response appears in that one frame only. A request on a sync edge goes to the following frame. A newer request replaces an unsent one.
- R7: Tag bits 14 and 13 are both 1 in a frame that carries a response and both 0 otherwise. Tag bit (15-s) flags slot s. Tag bits 2..0 are 0.
- R8: Tag bit 15 is 1 exactly when at least one of slots 1 to 12 carries data.
- R9: Slot 12 carries `{gp_bits, gp_irq}` and tag bit 3 is set when `gp_valid` is high at the sync edge. Otherwise slot 12 and tag bit 3 are 0.
- R10: If no sync pulse arrives within 256 clocks after a load, `sdata` stays 0 until the next sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse that loads a new frame |
| adc_left | input | 20 | Left ADC sample |
| adc_right | input | 20 | Right ADC sample |
| adc_valid | input | 1 | ADC samples are present for this frame |
| rsp_req | input | 1 | Pulse recording a register-read response |
| rsp_addr | input | 7 | Register index of the response |
| rsp_data | input | 16 | Read data of the response |
| gp_bits | input | 19 | General-purpose status bits |
| gp_irq | input | 1 | Audio interrupt indication |
| gp_valid | input | 1 | Slot 12 carries status this frame |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 7 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| sdata | output | 1 | Serial frame output, MSB first |

## Verification
The first bit of a frame appears on `sdata` right after the sync edge that loads it. Bit k of the frame follows k edges later. A response request or a selection write shows up only in the frame loaded at the next sync edge after it, never earlier. The bench model applies each input change at the edge where the design would sample it. It keeps the expected bit stream in a queue, and on every falling edge compares the next expected bit with `sdata`. Each comparison is named by the requirement that owns that bit position in the frame.

// File: rtl/slink_frame_asm.sv
`timescale 1ns/1ps
module slink_frame_asm #(
  parameter logic [6:0] CFG_INDEX = 7'h6E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_sync,
  input  logic [19:0] adc_left,
  input  logic [19:0] adc_right,
  input  logic        adc_valid,
  input  logic        rsp_req,
  input  logic [6:0]  rsp_addr,
  input  logic [15:0] rsp_data,
  input  logic [18:0] gp_bits,
  input  logic        gp_irq,
  input  logic        gp_valid,
  input  logic        cfg_wr,
  input  logic [6:0]  cfg_idx,
  input  logic [15:0] cfg_wdata,
  output logic        sdata
);

  logic [2:0]        pair_sel;
  logic              pend;
  logic [6:0]        pend_addr;
  logic [15:0]       pend_data;
  logic [3:0]        lsl, rsl;
  logic [12:1][19:0] slots;
  logic [12:1]       vld;
  logic [15:0]       tag;
  logic [255:0]      frame_next;
  logic [255:0]      shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pair_sel <= '0;
    else if (cfg_wr && cfg_idx == CFG_INDEX) pair_sel <= cfg_wdata[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (rsp_req) begin
      pend      <= 1'b1;
      pend_addr <= rsp_addr;
      pend_data <= rsp_data;
    end else if (frame_sync) begin
      pend      <= 1'b0;
    end

  always_comb
    case (pair_sel)
      3'd1:    begin lsl = 4'd7;  rsl = 4'd8;  end
      3'd2:    begin lsl = 4'd6;  rsl = 4'd9;  end
      3'd3:    begin lsl = 4'd10; rsl = 4'd11; end
      default: begin lsl = 4'd3;  rsl = 4'd4;  end
    endcase

  always_comb begin
    slots = '0;
    vld   = '0;
    if (pend) begin
      slots[1] = {1'b0, pend_addr, 12'h000};
      slots[2] = {pend_data, 4'h0};
      vld[1]   = 1'b1;
      vld[2]   = 1'b1;
    end
    if (adc_valid) begin
      slots[lsl] = adc_left;
      slots[rsl] = adc_right;
      vld[lsl]   = 1'b1;
      vld[rsl]   = 1'b1;
    end
    if (gp_valid) begin
      slots[12] = {gp_bits, gp_irq};
      vld[12]   = 1'b1;
    end
  end

  assign tag[15]  = |vld;
  assign tag[2:0] = 3'b000;
  assign frame_next[255:240] = tag;

  for (genvar s = 1; s <= 12; s++) begin : g_slot
    assign tag[15-s] = vld[s];
    assign frame_next[239-20*(s-1) -: 20] = slots[s];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (frame_sync) shreg <= frame_next;
    else shreg <= {shreg[254:0], 1'b0};

  assign sdata = shreg[255];

  // R2
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> shreg == {$past(shreg[254:0]), 1'b0});

  // R6
  atomic_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> shreg[254] == shreg[253]);

  // R6
  rsp_sent_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && pend && !rsp_req |=> !pend && shreg[254]);

  // R4
  foreign_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_idx != CFG_INDEX |=> $stable(pair_sel));

  // R7
  low_tag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> shreg[242:240] == 3'b000);

  // R9
  gp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> shreg[243] == $past(gp_valid));

endmodule

// File: tb/slink_frame_asm_tb.sv
`timescale 1ns/1ps
module slink_frame_asm_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic [19:0] adc_left = '0, adc_right = '0;
  logic        adc_valid = 1'b0;
  logic        rsp_req = 1'b0;
  logic [6:0]  rsp_addr = '0;
  logic [15:0] rsp_data = '0;
  logic [18:0] gp_bits = '0;
  logic        gp_irq = 1'b0;
  logic        gp_valid = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic        sdata;

  slink_frame_asm dut_i (.*);

  int    n_checks = 0, n_fail = 0;
  bit    exp_bit = 0;
  int    pos = -1;
  bit    q[$];
  int    m_sel = 0;
  bit    m_pend = 0;
  logic [6:0]  m_addr = '0;
  logic [15:0] m_data = '0;
  string phase = "R1 reset";
  bit    done = 0;

  function automatic string req_of(int p);
    if (p < 0) return "R1";
    if (p == 0) return "R8";
    if (p == 1 || p == 2 || (p >= 13 && p <= 15)) return "R7";
    if (p == 12) return "R9";
    if (p < 16) return "R3";
    if (p < 56) return "R6";
    if (p >= 256) return "R10";
    if (p >= 236) return "R9";
    if ((p - 16) / 20 + 1 == 5) return "R2";
    return "R3";
  endfunction

  task automatic build_frame();
    int ls, rs;
    logic [19:0] val [1:12];
    bit v [1:12];
    bit any = 0;
    case (m_sel)
      1: begin ls = 7;  rs = 8;  end
      2: begin ls = 6;  rs = 9;  end
      3: begin ls = 10; rs = 11; end
      default: begin ls = 3; rs = 4; end
    endcase
    for (int s = 1; s <= 12; s++) begin val[s] = '0; v[s] = 0; end
    if (m_pend) begin
      v[1] = 1; val[1] = {1'b0, m_addr, 12'h000};
      v[2] = 1; val[2] = {m_data, 4'h0};
    end
    if (adc_valid) begin
      v[ls] = 1; val[ls] = adc_left;
      v[rs] = 1; val[rs] = adc_right;
    end
    if (gp_valid) begin v[12] = 1; val[12] = {gp_bits, gp_irq}; end
    for (int s = 1; s <= 12; s++) any |= v[s];
    q.delete();
    q.push_back(any);
    for (int s = 1; s <= 12; s++) q.push_back(v[s]);
    for (int k = 0; k < 3; k++) q.push_back(1'b0);
    for (int s = 1; s <= 12; s++)
      for (int b = 19; b >= 0; b--) q.push_back(val[s][b]);
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      q.delete(); exp_bit = 0; pos = -1; m_sel = 0; m_pend = 0;
      return;
    end
    if (frame_sync) begin
      build_frame();
      pos = 0;
      exp_bit = q.pop_front();
    end else begin
      if (pos >= 0) pos++;
      exp_bit = (q.size() > 0) ? q.pop_front() : 1'b0;
    end
    if (rsp_req) begin m_pend = 1; m_addr = rsp_addr; m_data = rsp_data; end
    else if (frame_sync) m_pend = 0;
    if (cfg_wr && cfg_idx == 7'h6E) m_sel = int'(cfg_wdata[2:0]);
  endtask

  task automatic tick();
    model_edge();
    @(negedge clk);
    n_checks++;
    if (sdata !== exp_bit) begin
      n_fail++;
      $display("FAIL %s [%s] frame bit %0d: sdata=%0b expected %0b",
               req_of(pos), phase, pos, sdata, exp_bit);
    end
  endtask

  task automatic frame(int len, int req_at, logic [6:0] a, logic [15:0] d);
    for (int i = 0; i < len; i++) begin
      frame_sync = (i == 0);
      rsp_req    = (i == req_at);
      if (i == req_at) begin rsp_addr = a; rsp_data = d; end
      tick();
    end
    frame_sync = 0; rsp_req = 0;
  endtask

  task automatic cfg(logic [6:0] idx, logic [15:0] val);
    cfg_wr = 1; cfg_idx = idx; cfg_wdata = val;
    tick();
    cfg_wr = 0;
  endtask

  task automatic samples(int k);
    adc_left  = 20'hA5000 ^ 20'(k * 37);
    adc_right = 20'h5A0F0 ^ 20'(k * 91);
    gp_bits   = 19'h2C3A1 ^ 19'(k * 13);
    gp_irq    = k[0];
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 4; i++) tick();
    rst_n = 1;
    phase = "R1 idle after reset";
    for (int i = 0; i < 4; i++) tick();

    phase = "R2 default pair 3/4";
    adc_valid = 1; gp_valid = 1; samples(1);
    frame(256, -1, '0, '0);

    phase = "R6 response request";
    samples(2);
    frame(256, 40, 7'h2C, 16'hBEEF);
    phase = "R6 response carried";
    samples(3);
    frame(256, -1, '0, '0);
    phase = "R6 response gone";
    samples(4);
    frame(256, -1, '0, '0);

    for (int c = 1; c <= 3; c++) begin
      phase = $sformatf("R3 R4 select code %0d", c);
      cfg(7'h6E, 16'(c));
      samples(4 + c);
      frame(256, 100 + c, 7'(c * 17), 16'(c * 4099));
    end

    phase = "R5 fallback code 6";
    cfg(7'h6E, 16'h0006);
    samples(9);
    frame(256, -1, '0, '0);
    phase = "R5 fallback code 4";
    cfg(7'h6E, 16'hFFF4);
    samples(10);
    frame(256, -1, '0, '0);

    phase = "R4 foreign index ignored";
    cfg(7'h70, 16'h0003);
    samples(11);
    frame(256, -1, '0, '0);

    phase = "R6 request on sync edge, short frame";
    samples(12);
    frame(100, 0, 7'h7F, 16'h1234);
    samples(13);
    frame(256, -1, '0, '0);
    samples(14);
    frame(256, -1, '0, '0);

    phase = "R8 R10 empty frame, long gap";
    adc_valid = 0; gp_valid = 0;
    frame(300, -1, '0, '0);

    phase = "R9 status only";
    gp_valid = 1; samples(15);
    frame(256, -1, '0, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule